// File: doc/BRIEF.md
# Static Branch Predictor with Mispredict Redirect

This block sits in the decode stage of an in-order pipeline and guesses the direction of each branch before its condition is known. A branch whose target is relative to its own address is either always guessed taken (unconditional) or guessed taken only when it jumps backwards (conditional, negative displacement). A branch that takes its target from a register is always guessed not taken, because that target is unknown at decode. A taken guess sends a one-cycle flush and redirect toward fetch with the computed target.

The guess travels with the instruction into a one-entry resolution slot. In the next cycle the surrounding logic supplies the real outcome and, for register branches, the real target. The block redirects fetch a second time only when the guess was wrong. It picks the recovery address from the direction of the error. When both stages want to redirect in the same cycle, the older instruction in the resolution slot wins and the younger instruction in decode is dropped.

Top module: `brp_unit`

## Requirements
- R1: A valid instruction of kind unconditional-relative (code 2'b01) is guessed taken; one cycle later `redir_valid` is 1 with `redir_from_res` 0.
- R2: A conditional-relative instruction (code 2'b10) is guessed taken exactly when bit DW-1 of `dec_disp` is 1 (negative displacement); otherwise it causes no decode redirect.
- R3: A register-target instruction (code 2'b11) is always guessed not taken and never causes a decode redirect.
- R4: The predicted target, shown on `redir_pc` for a taken guess and on `ex_target`, equals `dec_pc` plus the sign-extended `dec_disp`, modulo 2^AW.
- R5: The decode redirect is registered: it appears in the cycle after the instruction is presented and lasts one cycle for each taken guess.
- R6: One cycle after a valid instruction is presented and not discarded, `ex_valid` is 1 and `ex_pc`, `ex_kind`, `ex_target` and `ex_pred_taken` (the guess) hold its values.
- R7: While `ex_valid` is 1 and the instruction is a branch, `redir_valid` and `redir_from_res` are 1 in the next cycle if and only if `res_taken` differs from `ex_pred_taken`.
- R8: On a mispredict, the recovery address is `ex_pc + 4` if the guess was taken. If the guess was not taken, it is `res_reg_target` for a register branch and `ex_target` for a relative branch.
- R9: If a mispredict and a decode-stage instruction fall in the same cycle, the resolution redirect is issued. The decode instruction causes no redirect and does not enter the slot (`ex_valid` 0 next cycle).
- R10: A non-branch (code 2'b00) is carried with `ex_pred_taken` 0, causes no decode redirect, and its `res_taken` value causes no resolution redirect.
- R11: After reset, `redir_valid`, `redir_from_res` and `ex_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dec_valid | input | 1 | Instruction present in decode |
| dec_pc | input | AW | Address of the decode instruction |
| dec_kind | input | 2 | 00 none, 01 unconditional relative, 10 conditional relative, 11 register target |
| dec_disp | input | DW | Signed branch displacement in bytes |
| ex_valid | output | 1 | Resolution slot holds an instruction |
| ex_pc | output | AW | Address of the slot instruction |
| ex_kind | output | 2 | Kind code of the slot instruction |
| ex_pred_taken | output | 1 | Guess carried with the slot instruction |
| ex_target | output | AW | Relative target of the slot instruction |
| res_taken | input | 1 | Real direction of the slot instruction |
| res_reg_target | input | AW | Real target of a register branch in the slot |
| redir_valid | output | 1 | Flush and redirect fetch this cycle |
| redir_pc | output | AW | Address fetch restarts from |
| redir_from_res | output | 1 | Redirect came from the resolution stage |

## Verification
The decode-stage taken redirect and the resolution-stage mispredict redirect can arise in the same cycle. This happens when a branch in the slot resolves against its guess while the next instruction, itself guessed taken, sits in decode. The bench builds this pairing from every combination of older-branch guess, actual outcome and younger-branch kind. It judges the result by the redirect address and source, the slot being empty afterwards, and the absence of any later redirect from the dropped instruction. A sweep of every kind, displacement and outcome on a small address width covers the direction rules, wraparound of the target sum and recovery selection.

// File: rtl/brp_pkg.sv
// Shared definitions for the static branch predictor.
// Assumes the instruction size is fixed at four bytes.
package brp_pkg;

    typedef enum logic [1:0] {
        BK_NONE   = 2'b00,
        BK_UNCOND = 2'b01,
        BK_COND   = 2'b10,
        BK_REG    = 2'b11
    } br_kind_e;

    localparam int INSN_BYTES = 4;

endpackage

// File: rtl/brp_predict.sv
// Decode-side direction guess and relative target adder.
// Purely combinational. Assumes dec_disp is a two's complement byte offset.
module brp_predict
    import brp_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 16
) (
    input  logic          valid,
    input  logic [AW-1:0] pc,
    input  logic [1:0]    kind,
    input  logic [DW-1:0] disp,
    output logic          pred_taken,
    output logic [AW-1:0] target
);

    logic [AW-1:0] disp_ext;
    br_kind_e      kind_e;

    assign kind_e = br_kind_e'(kind);

    // Sign extension or truncation of the displacement, picked by width.
    generate
        if (DW < AW) begin : g_extend
            assign disp_ext = {{(AW-DW){disp[DW-1]}}, disp};
        end else begin : g_trunc
            assign disp_ext = disp[AW-1:0];
        end
    endgenerate

    // Target wraps at the address width.
    assign target = pc + disp_ext;

    // Direction rule per branch kind.
    always_comb begin
        unique case (kind_e)
            BK_UNCOND: pred_taken = valid;
            BK_COND:   pred_taken = valid & disp[DW-1];
            default:   pred_taken = 1'b0;
        endcase
    end

endmodule

// File: rtl/brp_resolve.sv
// Resolution-stage mispredict detection and recovery address choice.
// Purely combinational; the real outcome arrives in the same cycle.
module brp_resolve
    import brp_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          ex_valid,
    input  logic [1:0]    ex_kind,
    input  logic          ex_pred,
    input  logic [AW-1:0] ex_pc,
    input  logic [AW-1:0] ex_target,
    input  logic          res_taken,
    input  logic [AW-1:0] res_reg_target,
    output logic          mispredict,
    output logic [AW-1:0] recover_pc
);

    localparam logic [AW-1:0] STEP = AW'(INSN_BYTES);

    logic is_branch;
    assign is_branch = (br_kind_e'(ex_kind) != BK_NONE);

    // Wrong guess only for a branch whose direction disagrees.
    assign mispredict = ex_valid & is_branch & (res_taken != ex_pred);

    // Fall-through after a bad taken guess, else the real target.
    always_comb begin
        if (ex_pred)
            recover_pc = ex_pc + STEP;
        else if (br_kind_e'(ex_kind) == BK_REG)
            recover_pc = res_reg_target;
        else
            recover_pc = ex_target;
    end

endmodule

// File: rtl/brp_carry.sv
// One-entry slot carrying a decoded instruction and its guess to resolution.
// A same-cycle mispredict discards the incoming (younger) instruction.
module brp_carry #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          kill,
    input  logic [AW-1:0] in_pc,
    input  logic [1:0]    in_kind,
    input  logic          in_pred,
    input  logic [AW-1:0] in_target,
    output logic          out_valid,
    output logic [AW-1:0] out_pc,
    output logic [1:0]    out_kind,
    output logic          out_pred,
    output logic [AW-1:0] out_target
);

    // Valid bit: cleared by reset or by a flush from resolution.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_valid <= 1'b0;
        else
            out_valid <= in_valid & ~kill;
    end

    // Payload: captured whenever a live instruction enters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_pc     <= '0;
            out_kind   <= '0;
            out_pred   <= 1'b0;
            out_target <= '0;
        end else if (in_valid & ~kill) begin
            out_pc     <= in_pc;
            out_kind   <= in_kind;
            out_pred   <= in_pred;
            out_target <= in_target;
        end
    end

endmodule

// File: rtl/brp_redirect.sv
// Registered fetch redirect with resolution-over-decode priority.
// Assumes each request is already qualified by its stage's valid.
module brp_redirect #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          res_req,
    input  logic [AW-1:0] res_pc,
    input  logic          dec_req,
    input  logic [AW-1:0] dec_pc,
    output logic          redir_valid,
    output logic [AW-1:0] redir_pc,
    output logic          redir_from_res
);

    // Register the winning request for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redir_valid    <= 1'b0;
            redir_pc       <= '0;
            redir_from_res <= 1'b0;
        end else begin
            redir_valid    <= res_req | dec_req;
            redir_from_res <= res_req;
            if (res_req)
                redir_pc <= res_pc;
            else if (dec_req)
                redir_pc <= dec_pc;
        end
    end

endmodule

// File: rtl/brp_unit.sv
// Static branch predictor with decode redirect and mispredict recovery.
// Decode guesses from kind and displacement sign; the slot instruction is
// resolved one cycle later with an externally supplied outcome.
// Assumes DW <= AW for a meaningful sign extension.
module brp_unit #(
    parameter int AW = 32,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dec_valid,
    input  logic [AW-1:0] dec_pc,
    input  logic [1:0]    dec_kind,
    input  logic [DW-1:0] dec_disp,
    output logic          ex_valid,
    output logic [AW-1:0] ex_pc,
    output logic [1:0]    ex_kind,
    output logic          ex_pred_taken,
    output logic [AW-1:0] ex_target,
    input  logic          res_taken,
    input  logic [AW-1:0] res_reg_target,
    output logic          redir_valid,
    output logic [AW-1:0] redir_pc,
    output logic          redir_from_res
);

    logic          guess;
    logic [AW-1:0] guess_tgt;
    logic          mis;
    logic [AW-1:0] rec_pc;

    brp_predict #(.AW(AW), .DW(DW)) u_pred (
        .valid      (dec_valid),
        .pc         (dec_pc),
        .kind       (dec_kind),
        .disp       (dec_disp),
        .pred_taken (guess),
        .target     (guess_tgt)
    );

    brp_resolve #(.AW(AW)) u_res (
        .ex_valid       (ex_valid),
        .ex_kind        (ex_kind),
        .ex_pred        (ex_pred_taken),
        .ex_pc          (ex_pc),
        .ex_target      (ex_target),
        .res_taken      (res_taken),
        .res_reg_target (res_reg_target),
        .mispredict     (mis),
        .recover_pc     (rec_pc)
    );

    brp_carry #(.AW(AW)) u_carry (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (dec_valid),
        .kill       (mis),
        .in_pc      (dec_pc),
        .in_kind    (dec_kind),
        .in_pred    (guess),
        .in_target  (guess_tgt),
        .out_valid  (ex_valid),
        .out_pc     (ex_pc),
        .out_kind   (ex_kind),
        .out_pred   (ex_pred_taken),
        .out_target (ex_target)
    );

    brp_redirect #(.AW(AW)) u_redir (
        .clk            (clk),
        .rst_n          (rst_n),
        .res_req        (mis),
        .res_pc         (rec_pc),
        .dec_req        (guess & ~mis),
        .dec_pc         (guess_tgt),
        .redir_valid    (redir_valid),
        .redir_pc       (redir_pc),
        .redir_from_res (redir_from_res)
    );

endmodule

// File: rtl/brp_unit_chk.sv
// Port-level properties of brp_unit, attached by bind.
module brp_unit_chk #(
    parameter int AW = 32,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          dec_valid,
    input logic [AW-1:0] dec_pc,
    input logic [1:0]    dec_kind,
    input logic [DW-1:0] dec_disp,
    input logic          ex_valid,
    input logic [AW-1:0] ex_pc,
    input logic [1:0]    ex_kind,
    input logic          ex_pred_taken,
    input logic [AW-1:0] ex_target,
    input logic          res_taken,
    input logic [AW-1:0] res_reg_target,
    input logic          redir_valid,
    input logic [AW-1:0] redir_pc,
    input logic          redir_from_res
);

    logic mis_seen;
    assign mis_seen = ex_valid & (ex_kind != 2'b00) & (res_taken != ex_pred_taken);

    p_uncond_taken_r1: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid && dec_kind == 2'b01 && !mis_seen |=> redir_valid && !redir_from_res);

    p_cond_sign_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid && dec_kind == 2'b10 && !mis_seen |=> redir_valid == $past(dec_disp[DW-1]));

    p_reg_not_taken_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid && dec_kind == 2'b11 && !mis_seen |=> !redir_valid);

    generate
        if (DW < AW) begin : g_tgt
            p_target_sum_r4: assert property (@(posedge clk) disable iff (!rst_n)
                dec_valid && dec_kind == 2'b01 && !mis_seen |=>
                redir_pc == $past(dec_pc + {{(AW-DW){dec_disp[DW-1]}}, dec_disp}));
        end
    endgenerate

    p_carry_guess_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid && !mis_seen |=> ex_valid && ex_pc == $past(dec_pc) && ex_kind == $past(dec_kind));

    p_mis_redirect_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mis_seen |=> redir_valid && redir_from_res);

    p_no_false_res_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mis_seen |=> !redir_from_res);

    p_fallthrough_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mis_seen && ex_pred_taken |=> redir_pc == $past(ex_pc) + AW'(4));

    p_priority_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mis_seen && dec_valid |=> !ex_valid);

    p_nonbranch_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid && dec_kind == 2'b00 && !mis_seen |=> !redir_valid && !ex_pred_taken);

endmodule

bind brp_unit brp_unit_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .dec_valid      (dec_valid),
    .dec_pc         (dec_pc),
    .dec_kind       (dec_kind),
    .dec_disp       (dec_disp),
    .ex_valid       (ex_valid),
    .ex_pc          (ex_pc),
    .ex_kind        (ex_kind),
    .ex_pred_taken  (ex_pred_taken),
    .ex_target      (ex_target),
    .res_taken      (res_taken),
    .res_reg_target (res_reg_target),
    .redir_valid    (redir_valid),
    .redir_pc       (redir_pc),
    .redir_from_res (redir_from_res)
);

// File: tb/sim_brp_unit.sv
// Sweep bench for brp_unit on a 10-bit address, 6-bit displacement build.
module sim_brp_unit;

    localparam int AW = 10;
    localparam int DW = 6;
    localparam int CLK_PERIOD = 10;
    localparam int MASK = (1 << AW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dec_valid = 1'b0;
    logic [AW-1:0] dec_pc = '0;
    logic [1:0]    dec_kind = '0;
    logic [DW-1:0] dec_disp = '0;
    logic          ex_valid;
    logic [AW-1:0] ex_pc;
    logic [1:0]    ex_kind;
    logic          ex_pred_taken;
    logic [AW-1:0] ex_target;
    logic          res_taken = 1'b0;
    logic [AW-1:0] res_reg_target = '0;
    logic          redir_valid;
    logic [AW-1:0] redir_pc;
    logic          redir_from_res;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    brp_unit #(.AW(AW), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .dec_valid(dec_valid), .dec_pc(dec_pc), .dec_kind(dec_kind), .dec_disp(dec_disp),
        .ex_valid(ex_valid), .ex_pc(ex_pc), .ex_kind(ex_kind),
        .ex_pred_taken(ex_pred_taken), .ex_target(ex_target),
        .res_taken(res_taken), .res_reg_target(res_reg_target),
        .redir_valid(redir_valid), .redir_pc(redir_pc), .redir_from_res(redir_from_res)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int guess_of(input int k, input int d);
        return (k == 1 || (k == 2 && d >= 32)) ? 1 : 0;
    endfunction

    function automatic int tgt_of(input int pc, input int d);
        int sd;
        sd = (d >= 32) ? d - 64 : d;
        return (pc + sd) & MASK;
    endfunction

    function automatic int recov(input int pc, input int k, input int g, input int tgt, input int rt);
        if (g == 1) return (pc + 4) & MASK;
        if (k == 3) return rt;
        return tgt;
    endfunction

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 redir_valid", redir_valid, 0);
        chk("R11 redir_from_res", redir_from_res, 0);
        chk("R11 ex_valid", ex_valid, 0);
        rst_n = 1'b1;
        step();

        // Sweep every kind, displacement and outcome.
        for (int k = 0; k < 4; k++) begin
            for (int d = 0; d < 64; d++) begin
                for (int t = 0; t < 2; t++) begin
                    int pc, g, tgt, rt, mis;
                    pc  = (d * 52 + k * 200 + 1000) & 'h3FC;
                    g   = guess_of(k, d);
                    tgt = tgt_of(pc, d);
                    rt  = (pc ^ 'h2A8) & MASK;
                    dec_valid = 1'b1; dec_pc = AW'(pc); dec_kind = 2'(k); dec_disp = DW'(d);
                    step();
                    // R1 R2 R3 R10: decode redirect follows the guess
                    chk("R1/R2/R3/R10 decode redirect", redir_valid, g);
                    chk("R5 decode source", redir_from_res, 0);
                    if (g == 1) chk("R4 target", redir_pc, tgt);
                    chk("R6 ex_valid", ex_valid, 1);
                    chk("R6 ex_pred_taken", ex_pred_taken, g);
                    chk("R6 ex_pc", ex_pc, pc);
                    chk("R6 ex_kind", ex_kind, k);
                    chk("R4 ex_target", ex_target, tgt);
                    dec_valid = 1'b0; res_taken = t[0]; res_reg_target = AW'(rt);
                    mis = (k != 0 && t != g) ? 1 : 0;
                    step();
                    // R7 R8 R10: resolution redirect only on mismatch
                    chk("R7/R10 resolution redirect", redir_valid, mis);
                    chk("R7 resolution source", redir_from_res, mis);
                    if (mis == 1) chk("R8 recovery pc", redir_pc, recov(pc, k, g, tgt, rt));
                    chk("R6 slot empties", ex_valid, 0);
                    res_taken = ~t[0];
                    step();
                    // R5: one pulse per guess, nothing from an empty slot
                    chk("R5 single pulse", redir_valid, 0);
                end
            end
        end

        // R9: collision of a resolution and a decode request.
        for (int ga = 0; ga < 2; ga++) begin
            for (int ta = 0; ta < 2; ta++) begin
                for (int kb = 0; kb < 4; kb++) begin
                    int pa, da, ka, tga, pb, db, gb, tgb, mis;
                    pa  = 'h3F8;
                    ka  = 2;
                    da  = (ga == 1) ? 60 : 12;
                    tga = tgt_of(pa, da);
                    pb  = (pa + 4) & MASK;
                    db  = 40;
                    gb  = guess_of(kb, db);
                    tgb = tgt_of(pb, db);
                    dec_valid = 1'b1; dec_pc = AW'(pa); dec_kind = 2'(ka); dec_disp = DW'(da);
                    step();
                    chk("R2 older guess", redir_valid, ga);
                    dec_pc = AW'(pb); dec_kind = 2'(kb); dec_disp = DW'(db);
                    res_taken = ta[0];
                    mis = (ta != ga) ? 1 : 0;
                    step();
                    dec_valid = 1'b0;
                    if (mis == 1) begin
                        chk("R9 resolution wins", redir_from_res, 1);
                        chk("R9 redirect", redir_valid, 1);
                        chk("R9/R8 recovery pc", redir_pc, (ga == 1) ? pb : tga);
                        chk("R9 younger dropped", ex_valid, 0);
                    end else begin
                        chk("R9 decode proceeds", redir_valid, gb);
                        chk("R9 decode source", redir_from_res, 0);
                        if (gb == 1) chk("R9/R4 younger target", redir_pc, tgb);
                        chk("R9 younger enters", ex_valid, 1);
                    end
                    res_taken = (gb == 1) ? 1'b1 : 1'b0;
                    step();
                    chk("R9 no late redirect", redir_valid, 0);
                    step();
                end
            end
        end

        finished = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule